// File: doc/BRIEF.md
# Spread-Spectrum Fractional Clock Divider

The block derives a slower clock from a fast reference clock. The divide ratio is the fraction N = num_i / den_i. A phase accumulator advances by twice the denominator on every reference cycle. Each time it passes the numerator it flips the output, and it keeps the remainder. Every output period therefore lasts either floor(N) or ceil(N) reference cycles. Over den_i periods the error cancels exactly. The fraction may be any value of at least 2. Settings that would put the output outside its supported frequency range are not supported.

To lower radiated emissions, a triangular profile can be laid over the ratio. A position counter walks from 0 up to the ramp length and back down, one position per output period. The position times the ramp step is a signed offset added to the numerator.

- Down mode only lengthens the period, so the nominal ratio is the fastest point.
- Center mode subtracts half of the peak offset, so the swing sits evenly around the nominal ratio.

The peak-to-peak deviation is ss_step_i * ss_ramp_i / num_i. Software picks it in the 0.1 % to 2.5 % band. The modulation rate is f_out / (2 * ss_ramp_i), and software picks the ramp length to land near 31.5 kHz, within 30 to 33 kHz. The enable input acts at once and no glitch-free handover is promised. Each instance carries its own enable and its own profile.

Top module: `ss_frac_div`

## Requirements
- R1: While rst_ni is low, clk_o is low. Asserting rst_ni forces clk_o low without waiting for a clock edge.
- R2: With ss_en_i = 0 and 2*den_i <= num_i, every output period (rising edge to rising edge) lasts floor(num_i/den_i) or ceil(num_i/den_i) reference cycles. Any den_i consecutive periods span exactly num_i reference cycles.
- R3: The high phase and the low phase of clk_o differ by at most one reference cycle. For an even integer ratio they are equal.
- R4: Down spread is selected by ss_mode_i = 0 with ss_en_i = 1. The triangle position c starts at 0 and moves one step at each rising edge of clk_o: up to ss_ramp_i, then down to 0, and then it repeats. The period that begins at a rising edge uses the numerator num_i + ss_step_i*c, where c is the position after that edge's step. When this value divides evenly by den_i, the period is exactly that quotient.
- R5: Center spread is selected by ss_mode_i = 1, with the same triangle as R4. The numerator becomes num_i + ss_step_i*c - floor(ss_step_i*ss_ramp_i/2).
- R6: With ss_ramp_i = 0 the position stays at 0. Down spread then yields the nominal ratio, and center spread also yields it, because its half-offset is 0.
- R7: Clearing ss_en_i removes the offset at once. The period that starts at the rising edge where the enable was cleared, and every later period, are nominal. The position returns to 0.
- R8: Setting ss_en_i restarts the triangle from position 0. The first step is taken at the first rising edge seen while the enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| num_i | input | NUM_W | Ratio numerator |
| den_i | input | NUM_W | Ratio denominator |
| ss_en_i | input | 1 | Spread enable (1 = on) |
| ss_mode_i | input | 1 | 0 = down spread, 1 = center spread |
| ss_step_i | input | STEP_W | Numerator offset per triangle position |
| ss_ramp_i | input | RAMP_W | Output periods per triangle ramp |
| clk_o | output | 1 | Divided clock |

## Verification
Every result of this block is a period or a phase length. Each one is measured as the distance between two output edges that were both sampled on falling reference edges, so the fixed one-cycle register delay from the accumulator to clk_o cancels out. The triangle position changes on the reference edge that closes the cycle in which the rising output edge appears. Its effect therefore lands in the period that starts at that edge. The bench model advances its own position at each observed rise before it predicts the next period. Enable changes are applied on the falling edge inside the rise cycle, which places them on the period boundary that R7 and R8 define.

// File: rtl/ss_frac_div_pkg.sv
package ss_frac_div_pkg;

  typedef enum logic {
    SS_DOWN   = 1'b0,
    SS_CENTER = 1'b1
  } ss_mode_e;

  function automatic int unsigned max_w(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ss_frac_div_tri.sv
module ss_frac_div_tri
  import ss_frac_div_pkg::*;
#(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned RAMP_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     tick_i,
  input  ss_mode_e                 mode_i,
  input  logic [STEP_W-1:0]        step_i,
  input  logic [RAMP_W-1:0]        ramp_i,
  output logic [RAMP_W-1:0]        cnt_o,
  output logic [STEP_W+RAMP_W:0]   off_o
);

  localparam int unsigned PROD_W = STEP_W + RAMP_W;
  localparam int unsigned OFF_W  = PROD_W + 1;

  logic [RAMP_W-1:0]       cnt_q;
  logic                    up_q;
  logic [PROD_W-1:0]       prod;
  logic [PROD_W-1:0]       peak;
  logic signed [OFF_W-1:0] prod_s;
  logic signed [OFF_W-1:0] half_s;
  logic signed [OFF_W-1:0] off_s;

  // triangle position, one step per output period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      if (up_q && (cnt_q < ramp_i)) begin
        cnt_q <= cnt_q + 1'b1;
        up_q  <= ((cnt_q + 1'b1) != ramp_i);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        up_q  <= (cnt_q == RAMP_W'(1));
      end else begin
        up_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    prod   = PROD_W'(step_i) * PROD_W'(cnt_q);
    peak   = PROD_W'(step_i) * PROD_W'(ramp_i);
    prod_s = $signed({1'b0, prod});
    half_s = $signed({2'b00, peak[PROD_W-1:1]});
    if (!en_i)                   off_s = '0;
    else if (mode_i == SS_CENTER) off_s = prod_s - half_s;
    else                         off_s = prod_s;
  end

  assign cnt_o = cnt_q;
  assign off_o = off_s;

endmodule

// File: rtl/ss_frac_div_acc.sv
module ss_frac_div_acc #(
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] mod_i,
  output logic             clk_o,
  output logic             rise_o,
  output logic [ACC_W-1:0] phase_o
);

  logic [ACC_W-1:0] ph_q;
  logic             clk_q;
  logic             rise_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   rem;
  logic             wrap;

  always_comb begin
    sum  = {1'b0, ph_q} + {1'b0, inc_i};
    rem  = sum - {1'b0, mod_i};
    wrap = (sum >= {1'b0, mod_i});
  end

  // each wrap ends a half period; remainder carries the fraction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      clk_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      ph_q   <= wrap ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
      clk_q  <= clk_q ^ wrap;
      rise_q <= wrap & ~clk_q;
    end
  end

  assign clk_o   = clk_q;
  assign rise_o  = rise_q;
  assign phase_o = ph_q;

endmodule

// File: rtl/ss_frac_div.sv
module ss_frac_div
  import ss_frac_div_pkg::*;
#(
  parameter int unsigned NUM_W  = 16,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned RAMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [NUM_W-1:0]  den_i,
  input  logic              ss_en_i,
  input  logic              ss_mode_i,
  input  logic [STEP_W-1:0] ss_step_i,
  input  logic [RAMP_W-1:0] ss_ramp_i,
  output logic              clk_o
);

  localparam int unsigned PROD_W = STEP_W + RAMP_W;
  localparam int unsigned OFF_W  = PROD_W + 1;
  localparam int unsigned ACC_W  = max_w(NUM_W + 1, PROD_W) + 2;

  logic [RAMP_W-1:0]       tri_cnt;
  logic [OFF_W-1:0]        ss_off;
  logic                    acc_rise;
  logic [ACC_W-1:0]        acc_phase;
  logic signed [ACC_W-1:0] eff_num;
  logic [ACC_W-1:0]        acc_inc;

  ss_frac_div_tri #(
    .STEP_W (STEP_W),
    .RAMP_W (RAMP_W)
  ) u_tri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ss_en_i),
    .tick_i (acc_rise),
    .mode_i (ss_mode_e'(ss_mode_i)),
    .step_i (ss_step_i),
    .ramp_i (ss_ramp_i),
    .cnt_o  (tri_cnt),
    .off_o  (ss_off)
  );

  always_comb begin
    eff_num = $signed({{(ACC_W-NUM_W){1'b0}}, num_i})
            + $signed({{(ACC_W-OFF_W){ss_off[OFF_W-1]}}, ss_off});
    acc_inc = {{(ACC_W-NUM_W-1){1'b0}}, den_i, 1'b0};
  end

  ss_frac_div_acc #(
    .ACC_W (ACC_W)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (acc_inc),
    .mod_i   (eff_num),
    .clk_o   (clk_o),
    .rise_o  (acc_rise),
    .phase_o (acc_phase)
  );

endmodule

// File: rtl/ss_frac_div_chk.sv
module ss_frac_div_chk #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned RAMP_W = 10
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   en_i,
  input logic                   mode_i,
  input logic [STEP_W-1:0]      step_i,
  input logic [RAMP_W-1:0]      ramp_i,
  input logic [RAMP_W-1:0]      cnt_i,
  input logic [STEP_W+RAMP_W:0] off_i,
  input logic                   rise_i,
  input logic                   clk_o
);

  localparam int unsigned PROD_W = STEP_W + RAMP_W;
  localparam int unsigned OFF_W  = PROD_W + 1;

  logic [PROD_W-1:0]       peak;
  logic signed [OFF_W-1:0] peak_s;
  logic signed [OFF_W-1:0] half_s;
  logic signed [OFF_W-1:0] off_s;

  always_comb begin
    peak   = PROD_W'(step_i) * PROD_W'(ramp_i);
    peak_s = $signed({1'b0, peak});
    half_s = $signed({2'b00, peak[PROD_W-1:1]});
    off_s  = $signed(off_i);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_low_in_reset: assert (clk_o == 1'b0);
    end
  end

  a_r2_rise_is_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> (clk_o && !$past(clk_o)));

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_i <= ramp_i));

  a_r4_down_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mode_i) |-> (off_s >= 0 && off_s <= peak_s));

  a_r5_center_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i) |-> (off_s >= -half_s && off_s <= peak_s - half_s));

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0));

  a_r8_step_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> ($past(rise_i) || !$past(en_i)));

endmodule

bind ss_frac_div ss_frac_div_chk #(
  .STEP_W (STEP_W),
  .RAMP_W (RAMP_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (ss_en_i),
  .mode_i (ss_mode_i),
  .step_i (ss_step_i),
  .ramp_i (ss_ramp_i),
  .cnt_i  (tri_cnt),
  .off_i  (ss_off),
  .rise_i (acc_rise),
  .clk_o  (clk_o)
);

// File: tb/ss_frac_div_tb_top.sv
module ss_frac_div_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int NUM_W      = 16;
  localparam int STEP_W     = 8;
  localparam int RAMP_W     = 10;

  // num, den, shortest period, longest period
  localparam int VEC_N = 6;
  localparam int VEC [VEC_N][4] = '{
    '{200,  2, 100, 100},
    '{7,    2,   3,   4},
    '{1000, 3, 333, 334},
    '{13,   5,   2,   3},
    '{4,    2,   2,   2},
    '{90,   7,  12,  13}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_W-1:0]  num_i = 16'd200;
  logic [NUM_W-1:0]  den_i = 16'd2;
  logic              ss_en_i = 1'b0;
  logic              ss_mode_i = 1'b0;
  logic [STEP_W-1:0] ss_step_i = '0;
  logic [RAMP_W-1:0] ss_ramp_i = '0;
  logic              clk_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  // bench copy of the triangle position
  int m_c;
  bit m_up;

  ss_frac_div #(
    .NUM_W  (NUM_W),
    .STEP_W (STEP_W),
    .RAMP_W (RAMP_W)
  ) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .num_i     (num_i),
    .den_i     (den_i),
    .ss_en_i   (ss_en_i),
    .ss_mode_i (ss_mode_i),
    .ss_step_i (ss_step_i),
    .ss_ramp_i (ss_ramp_i),
    .clk_o     (clk_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic next_rise(output int t);
    logic p;
    p = clk_o;
    @(negedge clk_i);
    while (!(clk_o && !p)) begin
      p = clk_o;
      @(negedge clk_i);
    end
    t = cyc;
  endtask

  task automatic next_fall(output int t);
    logic p;
    p = clk_o;
    @(negedge clk_i);
    while (!(!clk_o && p)) begin
      p = clk_o;
      @(negedge clk_i);
    end
    t = cyc;
  endtask

  task automatic model_reset();
    m_c  = 0;
    m_up = 1'b1;
  endtask

  task automatic model_step(input int ramp);
    if (m_up && m_c < ramp) begin
      m_c  = m_c + 1;
      m_up = (m_c != ramp);
    end else if (m_c != 0) begin
      m_c  = m_c - 1;
      m_up = (m_c == 0);
    end else begin
      m_up = 1'b1;
    end
  endtask

  function automatic int exp_period(input int nn, input int nd, input bit center,
                                    input int step, input int ramp);
    int off;
    off = step * m_c - (center ? (step * ramp) / 2 : 0);
    return (nn + off) / nd;
  endfunction

  // spread run from reset: check nper periods against the model
  task automatic run_spread(input bit center, input int step, input int ramp,
                            input int nper, input string req);
    int tp, t, e;
    num_i     = 16'd200;
    den_i     = 16'd2;
    ss_mode_i = center;
    ss_step_i = STEP_W'(step);
    ss_ramp_i = RAMP_W'(ramp);
    ss_en_i   = 1'b1;
    do_reset();
    model_reset();
    next_rise(tp);
    model_step(ramp);
    for (int k = 0; k < nper; k++) begin
      next_rise(t);
      e = exp_period(200, 2, center, step, ramp);
      check((t - tp) == e, req, t - tp, e);
      tp = t;
      model_step(ramp);
    end
  endtask

  initial begin
    int t0, t1, tp, t, tf, hi, lo;
    bit bounds_ok;
    int bad;

    // R1: output low while reset is held
    repeat (4) @(negedge clk_i);
    check(clk_o == 1'b0, "R1 reset level", clk_o, 0);

    // R2: table of plain ratios, spread off
    for (int v = 0; v < VEC_N; v++) begin
      num_i   = NUM_W'(VEC[v][0]);
      den_i   = NUM_W'(VEC[v][1]);
      ss_en_i = 1'b0;
      do_reset();
      next_rise(t0);
      tp = t0;
      bounds_ok = 1'b1;
      bad = 0;
      for (int k = 0; k < VEC[v][1]; k++) begin
        next_rise(t);
        if ((t - tp) < VEC[v][2] || (t - tp) > VEC[v][3]) begin
          bounds_ok = 1'b0;
          bad = t - tp;
        end
        tp = t;
      end
      check(bounds_ok, "R2 period bounds", bad, VEC[v][2]);
      check((tp - t0) == VEC[v][0], "R2 span of den periods", tp - t0, VEC[v][0]);
    end

    // R1: asynchronous reset while the output is high
    next_rise(t);
    #1;
    rst_ni = 1'b0;
    #1;
    check(clk_o == 1'b0, "R1 async reset", clk_o, 0);
    @(negedge clk_i);

    // R3: odd integer ratio, phases differ by one
    num_i = 16'd9;
    den_i = 16'd1;
    do_reset();
    next_rise(t0);
    next_fall(tf);
    next_rise(t1);
    hi = tf - t0;
    lo = t1 - tf;
    check((hi + lo) == 9, "R3 odd period", hi + lo, 9);
    check((hi - lo) <= 1 && (lo - hi) <= 1, "R3 odd phase balance", hi - lo, 0);

    // R3: even integer ratio, equal phases
    num_i = 16'd10;
    do_reset();
    next_rise(t0);
    next_fall(tf);
    next_rise(t1);
    check((tf - t0) == 5, "R3 even high phase", tf - t0, 5);
    check((t1 - tf) == 5, "R3 even low phase", t1 - tf, 5);

    // R4: down spread, two full triangles
    run_spread(1'b0, 2, 5, 20, "R4 down period");

    // R5: center spread
    run_spread(1'b1, 2, 4, 16, "R5 center period");

    // R6: zero ramp length keeps the nominal ratio
    run_spread(1'b1, 5, 0, 4, "R6 center zero ramp");
    run_spread(1'b0, 5, 0, 4, "R6 down zero ramp");

    // R7: clear enable mid ramp
    run_spread(1'b0, 2, 5, 3, "R4 down before clear");
    next_rise(tp);
    ss_en_i = 1'b0;
    next_rise(t);
    check((t - tp) == 100, "R7 first period after clear", t - tp, 100);
    tp = t;
    next_rise(t);
    check((t - tp) == 100, "R7 second period after clear", t - tp, 100);
    tp = t;

    // R8: set enable again, triangle restarts at 0 and steps on this rise
    ss_en_i = 1'b1;
    model_reset();
    model_step(5);
    next_rise(t);
    check((t - tp) == 101, "R8 first period after set", t - tp, 101);
    tp = t;
    next_rise(t);
    check((t - tp) == 102, "R8 second period after set", t - tp, 102);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule